// File: doc/BRIEF.md
# Linear Image Sensor Readout Sequencer

This block walks a serial-output linear photodiode array through one complete readout. A frame begins with a start pulse on the sensor's shift-in line, framed by the first pixel clock. After that the sequencer asks an external converter for one sample per pixel. It advances the sensor clock as soon as each conversion reports completion, so the next pixel settles while the following conversion runs. It then hands each 8-bit result to a downstream store, together with the pixel's index. One extra clock after the last pixel parks the sensor output and resets its final sampling switch.

A second operation, clear, runs the same shift-in pulse and then clocks the array out at the fastest legal rate without sampling. This empties the array so that a fresh integration period begins. The 19th rising clock edge after the shift-in pulse opens the next integration window. The pixel count is an input, sampled when an operation starts. Requests that arrive while the block is busy wait their turn.

Top module: `linescan_seq`

## Requirements
- R1: An operation opens with SI rising while CLK is low. CLK rises exactly LO_CYC cycles later. SI falls exactly HI_CYC cycles after that rise, with CLK still high. CLK falls on the next cycle.
- R2: Every CLK high phase lasts at least HI_CYC cycles and at least 2 cycles. Every CLK low phase lasts at least LO_CYC cycles.
- R3: A frame issues exactly N one-cycle `adc_start` pulses. The first coincides with the falling CLK edge of the SI clock. Each later pulse coincides with a CLK rising edge.
- R4: In a frame, CLK rises on the edge at which `adc_done` is sampled high. If the low phase is still too short at that point, the completion is held and CLK rises at the first legal edge.
- R5: One cycle after each pixel rising edge, `pix_we` is high for one cycle. `pix_addr` counts 0..N-1 in order, and `pix_data` is the conversion result of that pixel. CLK then falls max(HI_CYC,2) cycles after the rise.
- R6: Every operation produces exactly N+1 CLK rising edges. A `pix_count` of 0 behaves as 1.
- R7: Clear mode holds CLK high for exactly HI_CYC cycles and low for exactly LO_CYC cycles. It raises neither `adc_start` nor `pix_we`.
- R8: `busy` rises one cycle after a request is accepted. It falls exactly LO_CYC cycles after the final CLK fall.
- R9: A request made while busy is held pending, and repeated requests merge. A pending operation starts on the cycle after `busy` falls. When both kinds are pending, or both arrive together while idle, clear runs first and start runs after it.
- R10: An `adc_done` that arrives with no conversion outstanding is ignored.
- R11: After reset, `si`, `sens_clk`, `adc_start`, `pix_we` and `busy` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | Request a sampled frame readout |
| clear_req | input | 1 | Request a clear pass without sampling |
| pix_count | input | PIX_W | Pixels in the array (0 acts as 1) |
| adc_done | input | 1 | Conversion complete pulse |
| adc_data | input | DATA_W | Conversion result, valid with adc_done |
| si | output | 1 | Sensor shift-in start pulse |
| sens_clk | output | 1 | Sensor pixel clock |
| adc_start | output | 1 | Conversion request pulse |
| pix_we | output | 1 | Pixel write strobe |
| pix_addr | output | PIX_W | Pixel index for the write |
| pix_data | output | DATA_W | Pixel sample for the write |
| busy | output | 1 | Operation in progress |

## Verification
The bench builds the block with HI_CYC=3 and LO_CYC=5. Because these widths differ, swapping or miscounting the two phase limits shows up as an edge in the wrong cycle. A minimum high width of 3 also keeps the store cycle strictly between rise and fall. PIX_W=11 allows a full 1280-pixel frame alongside counts of 0, 1 and 2. The converter model replies after one cycle, which forces completions to wait for the low width, or after fifteen cycles, or at random. This brings both branches of the rise rule in R4 within reach.

// File: rtl/lsq_pkg.sv
// Shared types for the linear sensor sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package lsq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SI_SET,
        ST_SI_HI,
        ST_SI_DROP,
        ST_WAIT,
        ST_STORE,
        ST_HIGH,
        ST_TAIL,
        ST_CLR_LO,
        ST_CLR_HI
    } seq_state_t;

    typedef enum logic {
        OP_FRAME,
        OP_CLEAR
    } op_kind_t;

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lsq_width_timer.sv
// Counts cycles since the sensor clock last changed level.
// Reports when the high and low minimum widths are met.
// Assumes: restart is pulsed on the edge where the clock level changes.
module lsq_width_timer #(
    parameter int unsigned HI_CYC = 7,
    parameter int unsigned LO_CYC = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic hi_ok,
    output logic lo_ok
);
    localparam int unsigned MAXW = lsq_pkg::max_u(HI_CYC, LO_CYC);
    localparam int unsigned CW   = $clog2(MAXW + 1);

    logic [CW-1:0] cnt;

    // Saturating count of cycles spent in the current level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= CW'(MAXW);
        end else if (restart) begin
            cnt <= CW'(1);
        end else if (cnt != CW'(MAXW)) begin
            cnt <= cnt + CW'(1);
        end
    end

    assign hi_ok = (cnt >= CW'(HI_CYC));
    assign lo_ok = (cnt >= CW'(LO_CYC));

    // R2: a fresh level can never be reported as already wide enough.
    assert_restart_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == CW'(1)));

endmodule

// File: rtl/lsq_req_latch.sv
// Holds start and clear requests until the sequencer is idle.
// Clear has priority over start.
// Assumes: requests are single-cycle or level; repeats merge.
module lsq_req_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic clear_req,
    input  logic idle,
    output logic go_frame,
    output logic go_clear
);
    logic pend_s, pend_c;
    logic eff_s, eff_c;

    assign eff_c    = pend_c | clear_req;
    assign eff_s    = pend_s | start_req;
    assign go_clear = idle & eff_c;
    assign go_frame = idle & ~eff_c & eff_s;

    // Keep each request kind pending until it is launched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_s <= 1'b0;
            pend_c <= 1'b0;
        end else begin
            pend_c <= eff_c & ~go_clear;
            pend_s <= eff_s & ~go_frame;
        end
    end

    // R9: a start request seen while busy is remembered.
    assert_start_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && start_req) |=> pend_s);

    // R9: a clear request seen while busy is remembered.
    assert_clear_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && clear_req) |=> pend_c);

    // R9: never launch both operations at once.
    assert_one_launch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({go_frame, go_clear}));

endmodule

// File: rtl/lsq_sample_cap.sv
// Tracks the outstanding conversion and holds an early completion.
// Holds the result until the sequencer takes it.
// Assumes: at most one conversion is in flight at a time.
module lsq_sample_cap #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adc_start,
    input  logic              adc_done,
    input  logic [DATA_W-1:0] adc_data,
    input  logic              take,
    output logic              avail,
    output logic [DATA_W-1:0] data
);
    logic              outst;
    logic              seen;
    logic [DATA_W-1:0] hold;
    logic              acc_done;

    assign acc_done = adc_done & outst;
    assign avail    = seen | acc_done;
    assign data     = seen ? hold : adc_data;

    // Mark a conversion in flight from request to completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outst <= 1'b0;
        end else if (adc_start) begin
            outst <= 1'b1;
        end else if (acc_done) begin
            outst <= 1'b0;
        end
    end

    // Park a completion that the sequencer cannot use yet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen <= 1'b0;
            hold <= '0;
        end else if (take) begin
            seen <= 1'b0;
        end else if (acc_done) begin
            seen <= 1'b1;
            hold <= adc_data;
        end
    end

    // R10: a completion with nothing in flight leaves no trace.
    assert_stray_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_done && !outst && !seen) |=> !seen);

endmodule

// File: rtl/linescan_seq.sv
// Top of the linear sensor readout sequencer.
// Generates SI and the pixel clock, requests one conversion per pixel,
// and writes each result with its index. Also runs a sample-free clear.
// Assumes: the converter answers each adc_start with one adc_done pulse
// at least one cycle later; HI_CYC and LO_CYC are at least 1.
module linescan_seq #(
    parameter int unsigned PIX_W  = 11,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned HI_CYC = 7,
    parameter int unsigned LO_CYC = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              clear_req,
    input  logic [PIX_W-1:0]  pix_count,
    input  logic              adc_done,
    input  logic [DATA_W-1:0] adc_data,
    output logic              si,
    output logic              sens_clk,
    output logic              adc_start,
    output logic              pix_we,
    output logic [PIX_W-1:0]  pix_addr,
    output logic [DATA_W-1:0] pix_data,
    output logic              busy
);
    import lsq_pkg::*;

    localparam logic [PIX_W-1:0] ONE = PIX_W'(1);

    seq_state_t        state;
    op_kind_t          kind;
    logic [PIX_W-1:0]  last_idx, idx, rem, n_eff;
    logic              si_q, clk_q, adc_start_q, we_q;
    logic [PIX_W-1:0]  addr_q;
    logic [DATA_W-1:0] data_q;

    logic              idle, go_frame, go_clear, accept;
    logic              hi_ok, lo_ok, tmr_restart;
    logic              cap_avail;
    logic [DATA_W-1:0] cap_data;
    logic              si_rise, frm_rise, clr_rise, any_fall;

    assign idle   = (state == ST_IDLE);
    assign accept = go_frame | go_clear;
    assign n_eff  = (pix_count == '0) ? ONE : pix_count;

    // Edge decisions taken this cycle.
    always_comb begin
        si_rise  = (state == ST_SI_SET) && lo_ok;
        frm_rise = (state == ST_WAIT) && cap_avail && lo_ok;
        clr_rise = (state == ST_CLR_LO) && lo_ok && (rem != '0);
        any_fall = (state == ST_SI_DROP)
                || ((state == ST_HIGH) && hi_ok)
                || ((state == ST_CLR_HI) && hi_ok);
        tmr_restart = accept | si_rise | frm_rise | clr_rise | any_fall;
    end

    lsq_req_latch u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .clear_req (clear_req),
        .idle      (idle),
        .go_frame  (go_frame),
        .go_clear  (go_clear)
    );

    lsq_width_timer #(
        .HI_CYC (HI_CYC),
        .LO_CYC (LO_CYC)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tmr_restart),
        .hi_ok   (hi_ok),
        .lo_ok   (lo_ok)
    );

    lsq_sample_cap #(
        .DATA_W (DATA_W)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .adc_start (adc_start_q),
        .adc_done  (adc_done),
        .adc_data  (adc_data),
        .take      (frm_rise),
        .avail     (cap_avail),
        .data      (cap_data)
    );

    // Sequencer: SI pulse, then per-pixel rise/store/fall or clear clocking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            kind        <= OP_FRAME;
            last_idx    <= '0;
            idx         <= '0;
            rem         <= '0;
            si_q        <= 1'b0;
            clk_q       <= 1'b0;
            adc_start_q <= 1'b0;
            we_q        <= 1'b0;
            addr_q      <= '0;
            data_q      <= '0;
        end else begin
            adc_start_q <= 1'b0;
            we_q        <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        si_q     <= 1'b1;
                        kind     <= go_clear ? OP_CLEAR : OP_FRAME;
                        last_idx <= n_eff - ONE;
                        rem      <= n_eff;
                        idx      <= '0;
                        state    <= ST_SI_SET;
                    end
                end
                ST_SI_SET: begin
                    if (si_rise) begin
                        clk_q <= 1'b1;
                        state <= ST_SI_HI;
                    end
                end
                ST_SI_HI: begin
                    if (hi_ok) begin
                        si_q  <= 1'b0;
                        state <= ST_SI_DROP;
                    end
                end
                ST_SI_DROP: begin
                    clk_q <= 1'b0;
                    if (kind == OP_FRAME) begin
                        adc_start_q <= 1'b1;
                        state       <= ST_WAIT;
                    end else begin
                        state <= ST_CLR_LO;
                    end
                end
                ST_WAIT: begin
                    if (frm_rise) begin
                        clk_q       <= 1'b1;
                        data_q      <= cap_data;
                        addr_q      <= idx;
                        adc_start_q <= (idx != last_idx);
                        state       <= ST_STORE;
                    end
                end
                ST_STORE: begin
                    we_q  <= 1'b1;
                    state <= ST_HIGH;
                end
                ST_HIGH: begin
                    if (hi_ok) begin
                        clk_q <= 1'b0;
                        if (idx == last_idx) begin
                            state <= ST_TAIL;
                        end else begin
                            idx   <= idx + ONE;
                            state <= ST_WAIT;
                        end
                    end
                end
                ST_TAIL: begin
                    if (lo_ok) begin
                        state <= ST_IDLE;
                    end
                end
                ST_CLR_LO: begin
                    if (lo_ok) begin
                        if (rem == '0) begin
                            state <= ST_IDLE;
                        end else begin
                            clk_q <= 1'b1;
                            state <= ST_CLR_HI;
                        end
                    end
                end
                ST_CLR_HI: begin
                    if (hi_ok) begin
                        clk_q <= 1'b0;
                        rem   <= rem - ONE;
                        state <= ST_CLR_LO;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign si        = si_q;
    assign sens_clk  = clk_q;
    assign adc_start = adc_start_q;
    assign pix_we    = we_q;
    assign pix_addr  = addr_q;
    assign pix_data  = data_q;
    assign busy      = ~idle;

    // R1: SI only drops while the clock is high.
    assert_si_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(si_q) |-> clk_q);

    // R2: a rising edge only after the low width was met.
    assert_low_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_q) |-> $past(lo_ok));

    // R2: a falling edge only after the high width was met.
    assert_high_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_q) |-> $past(hi_ok));

    // R5: the store strobe sits inside a high phase, after the rise.
    assert_store_in_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        we_q |-> (clk_q && $past(clk_q)));

    // R7: clear mode never requests conversions or writes.
    assert_clear_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == OP_CLEAR && !idle) |-> (!adc_start_q && !we_q));

    // R8: outside an operation the sensor lines rest low.
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!clk_q && !si_q));

endmodule

// File: tb/linescan_seq_bench.sv
module linescan_seq_bench;
    localparam int HI = 3;
    localparam int LO = 5;
    localparam int PW = 11;
    localparam int DW = 8;
    localparam int K_FRAME = 0;
    localparam int K_CLEAR = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_req = 1'b0, clear_req = 1'b0;
    logic [PW-1:0] pix_count = '0;
    logic          adc_done = 1'b0;
    logic [DW-1:0] adc_data = '0;
    logic          si, sens_clk, adc_start, pix_we, busy;
    logic [PW-1:0] pix_addr;
    logic [DW-1:0] pix_data;

    always #4 clk = ~clk;

    linescan_seq #(.PIX_W(PW), .DATA_W(DW), .HI_CYC(HI), .LO_CYC(LO)) u_linescan_seq (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .clear_req(clear_req),
        .pix_count(pix_count), .adc_done(adc_done), .adc_data(adc_data),
        .si(si), .sens_clk(sens_clk), .adc_start(adc_start), .pix_we(pix_we),
        .pix_addr(pix_addr), .pix_data(pix_data), .busy(busy)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, fails = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int eff_n(input int n);
        return (n == 0) ? 1 : n;
    endfunction

    function automatic int exp_rise(input int done_c, input int fall_c);
        return (done_c + 1 > fall_c + LO) ? done_c + 1 : fall_c + LO;
    endfunction

    function automatic int hi_need();
        return (HI < 2) ? 2 : HI;
    endfunction

    // expected operation queue, in execution order
    int q_kind[64], q_n[64], q_chain[64], q_reqc[64];
    int q_wr = 0, q_rd = 0;

    task automatic push(input int k, input int n, input int chain, input int rc);
        q_kind[q_wr] = k; q_n[q_wr] = n; q_chain[q_wr] = chain; q_reqc[q_wr] = rc;
        q_wr++;
    endtask

    // monitor and converter model state
    bit pclk = 0, psi = 0, pbusy = 0, first_fall = 0, done_vld = 0;
    bit conv_pend = 0, stray = 0, tag_r10 = 0;
    int last_rise = 0, last_fall = 0, si_rise_c = 0, end_c = 0, done_c = 0;
    int rises = 0, starts = 0, writes = 0, next_addr = 0, conv = 0, done_at = 0;
    int cur_kind = 0, cur_n = 0, lat_mode = 0;
    logic [7:0] cur_val = '0;
    logic [7:0] exp_data [0:2047];

    always @(negedge clk) begin
        if (rst_n) begin
            if (busy && !pbusy) begin
                cur_kind = q_kind[q_rd];
                cur_n    = eff_n(q_n[q_rd]);
                if (q_chain[q_rd] != 0)
                    chk(cyc == end_c + 1, "R9", "pending op start cycle", cyc, end_c + 1);
                else
                    chk(cyc == q_reqc[q_rd] + 1, "R8", "busy rise cycle", cyc, q_reqc[q_rd] + 1);
                q_rd++;
                rises = 0; starts = 0; writes = 0; next_addr = 0; conv = 0;
                first_fall = 1; done_vld = 0;
            end
            if (si && !psi) begin
                si_rise_c = cyc;
                chk(!sens_clk, "R1", "clock low at SI rise", int'(sens_clk), 0);
            end
            if (!si && psi) begin
                chk(sens_clk, "R1", "clock high at SI fall", int'(sens_clk), 1);
                chk(cyc == last_rise + HI, "R1", "SI fall cycle", cyc, last_rise + HI);
            end
            if (sens_clk && !pclk) begin
                rises++;
                if (si) begin
                    chk(cyc == si_rise_c + LO, "R1", "SI clock rise cycle", cyc, si_rise_c + LO);
                end else begin
                    chk(cyc - last_fall >= LO, "R2", "low width", cyc - last_fall, LO);
                    if (cur_kind == K_FRAME) begin
                        chk(done_vld, "R4", "rise without completion", 0, 1);
                        chk(cyc == exp_rise(done_c, last_fall), "R4", "pixel rise cycle",
                            cyc, exp_rise(done_c, last_fall));
                        if (tag_r10) begin
                            chk(cyc == exp_rise(done_c, last_fall), "R10", "rise after stray done",
                                cyc, exp_rise(done_c, last_fall));
                            tag_r10 = 0;
                        end
                        done_vld = 0;
                    end else begin
                        chk(cyc == last_fall + LO, "R7", "clear low width", cyc - last_fall, LO);
                    end
                end
                last_rise = cyc;
            end
            if (!sens_clk && pclk) begin
                chk(cyc - last_rise >= HI, "R2", "high width", cyc - last_rise, HI);
                if (first_fall) begin
                    chk(!si, "R1", "SI low before clock fall", int'(si), 0);
                    chk(cyc == last_rise + HI + 1, "R1", "SI clock fall cycle", cyc, last_rise + HI + 1);
                    first_fall = 0;
                end else if (cur_kind == K_FRAME) begin
                    chk(cyc == last_rise + hi_need(), "R5", "pixel fall cycle", cyc, last_rise + hi_need());
                end else begin
                    chk(cyc == last_rise + HI, "R7", "clear high width", cyc - last_rise, HI);
                end
                last_fall = cyc;
            end
            if (adc_start) begin
                starts++;
                chk(sens_clk != pclk, "R3", "start on a clock edge", int'(sens_clk), int'(!pclk));
                conv_pend = 1;
                case (lat_mode)
                    1: done_at = cyc + 1;
                    2: done_at = cyc + 15;
                    default: done_at = cyc + $urandom_range(1, 12);
                endcase
                cur_val = 8'($urandom);
                exp_data[conv] = cur_val;
                conv++;
            end
            if (pix_we) begin
                writes++;
                chk(cyc == last_rise + 1, "R5", "store cycle", cyc, last_rise + 1);
                chk(int'(pix_addr) == next_addr, "R5", "store address", int'(pix_addr), next_addr);
                chk(pix_data == exp_data[next_addr], "R5", "store data",
                    int'(pix_data), int'(exp_data[next_addr]));
                next_addr++;
            end
            if (!busy && pbusy) begin
                chk(cyc == last_fall + LO, "R8", "busy fall cycle", cyc, last_fall + LO);
                chk(rises == cur_n + 1, "R6", "rising edges", rises, cur_n + 1);
                if (cur_kind == K_FRAME) begin
                    chk(starts == cur_n, "R3", "conversion requests", starts, cur_n);
                    chk(writes == cur_n, "R5", "pixel writes", writes, cur_n);
                end else begin
                    chk(starts == 0, "R7", "conversion requests in clear", starts, 0);
                    chk(writes == 0, "R7", "pixel writes in clear", writes, 0);
                end
                end_c = cyc;
            end
            if (conv_pend && cyc == done_at) begin
                adc_done = 1'b1; adc_data = cur_val;
                done_vld = 1; done_c = cyc; conv_pend = 0;
            end else if (stray) begin
                adc_done = 1'b1; adc_data = 8'h5A; stray = 0;
            end else begin
                adc_done = 1'b0;
            end
            pclk = sens_clk; psi = si; pbusy = busy;
        end
    end

    task automatic wait_idle();
        while (busy || q_rd != q_wr) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_op(input int k, input int n);
        @(negedge clk);
        pix_count = PW'(n);
        push(k, n, 0, cyc);
        if (k == K_CLEAR) clear_req = 1'b1; else start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0; clear_req = 1'b0;
        wait_idle();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R8 watchdog actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(!si && !sens_clk, "R11", "sensor lines after reset", int'(si) + int'(sens_clk), 0);
        chk(!adc_start && !pix_we, "R11", "strobes after reset", int'(adc_start) + int'(pix_we), 0);
        chk(!busy, "R11", "busy after reset", int'(busy), 0);

        // directed corners: single pixel, zero count, short and long latency
        lat_mode = 0; run_op(K_FRAME, 1);
        lat_mode = 1; run_op(K_FRAME, 0);
        run_op(K_CLEAR, 0);
        lat_mode = 2; run_op(K_FRAME, 2);
        lat_mode = 1; run_op(K_FRAME, 6);

        // R10: stray completion while idle must be ignored
        @(negedge clk); stray = 1;
        repeat (3) @(negedge clk);
        lat_mode = 2; tag_r10 = 1; run_op(K_FRAME, 3);

        // R9: requests while busy, with merge and clear priority
        lat_mode = 0;
        @(negedge clk);
        pix_count = PW'(4);
        push(K_FRAME, 4, 0, cyc);
        start_req = 1'b1;
        @(negedge clk); start_req = 1'b0;
        repeat (4) @(negedge clk);
        start_req = 1'b1;
        @(negedge clk); start_req = 1'b0; clear_req = 1'b1;
        @(negedge clk); clear_req = 1'b0; start_req = 1'b1;
        @(negedge clk); start_req = 1'b0;
        push(K_CLEAR, 4, 1, 0);
        push(K_FRAME, 4, 1, 0);
        wait_idle();

        // R9: both requests together while idle
        @(negedge clk);
        pix_count = PW'(2);
        push(K_CLEAR, 2, 0, cyc);
        push(K_FRAME, 2, 1, 0);
        start_req = 1'b1; clear_req = 1'b1;
        @(negedge clk); start_req = 1'b0; clear_req = 1'b0;
        wait_idle();

        // full default-size frame and clear
        lat_mode = 0; run_op(K_FRAME, 1280);
        run_op(K_CLEAR, 1280);

        // constrained random mix
        for (int i = 0; i < 16; i++) begin
            lat_mode = $urandom_range(0, 2);
            run_op(($urandom_range(0, 3) == 0) ? K_CLEAR : K_FRAME, $urandom_range(1, 40));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule